// File: doc/BRIEF.md
# AXI Channel Stall Injector

This block sits on one AXI channel and inserts latency on purpose. It passes the VALID/READY/payload triple from an upstream port to a downstream port. While a stall is active it holds downstream VALID and upstream READY low. The sender keeps its beat on the wire, so nothing is dropped. A stall can start in two ways. An unconditional stall can begin on any idle cycle. A conditional stall begins on a selected handshake event seen on the monitor inputs. Each kind of start can be made certain, or left to a pseudo-random draw compared against an 8-bit threshold. The stall length is either the programmed count or a pseudo-random value between 1 and that count.

Two 32-bit Galois LFSRs provide the randomness: one for the stall decision and one for the stall length. Each LFSR has a seed register and a feedback-polynomial register, and its state is readable. A small write port loads six internal registers at the addresses below. A global bypass, set at reset, keeps the channel transparent until software clears it.

Top module: `chan_stall_inj`

## Requirements
- R1: After reset the bypass is set, both LFSR enables are clear, all seeds, polynomials and LFSR states read 0xFFFFFFFF, and the channel is transparent even if a stall configuration is written at address 1.
- R2: When no stall is active, m_valid_o equals s_valid_i, s_ready_o equals m_ready_i, and m_data_o equals s_data_i.
- R3: While a stall is active, m_valid_o and s_ready_o are both 0.
- R4: Stall config (address 1): bits [8:0] hold the length N, bit 19 enables unconditional stalls and bit 20 makes them certain. With both set, the channel cycles through 1 open cycle followed by N stalled cycles. N = 0 never stalls.
- R5: With bit 17 (random length) set and N > 0, every stall lasts between 1 and N cycles, drawn from the low 9 bits of the length LFSR.
- R6: With bit 18 clear, a non-certain stall fires when the low 8 bits of the decision LFSR are below the threshold in bits [16:9].
- R7: With bit 18 set, a non-certain stall fires when the low 8 bits of the decision LFSR AND the threshold equal zero.
- R8: Bit 21 enables conditional stalls and bit 22 makes them certain. Bits 25..29 select triggers: RVALID with a non-OKAY RRESP; BVALID with a non-OKAY BRESP; WVALID with WLAST; ARVALID with ARREADY; AWVALID with AWREADY. Unselected or incomplete events start nothing.
- R9: With bit 23 (retrigger) set and bit 24 clear, a conditional hit during a stall sets the remaining count to (remaining − 1) + new length.
- R10: With bits 23 and 24 set, a retrigger sets the remaining count to max(remaining − 1, new length). With bit 23 clear, triggers during a stall have no effect.
- R11: Control (address 0): bit 0 is bypass, bit 1 enables the decision LFSR and bit 2 enables the length LFSR. An enabled LFSR steps once per clock as s' = (s >> 1) XOR (s[0] ? poly : 0). A disabled LFSR holds its state.
- R12: If a step would yield zero, the LFSR loads its seed instead.
- R13: Writing a seed (address 2 for the decision LFSR, address 4 for the length LFSR) loads the LFSR state in the same cycle. Addresses 3 and 5 hold the polynomials.
- R14: While bypass is set, no stall is visible, and an ongoing stall ends from the cycle after bypass is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select (0 control, 1 stall config, 2/3 decision seed/poly, 4/5 length seed/poly) |
| reg_wdata_i | input | REG_W | Write data |
| prob_state_o | output | LFSR_W | Live decision LFSR state |
| dly_state_o | output | LFSR_W | Live length LFSR state |
| s_valid_i | input | 1 | Upstream VALID |
| s_ready_o | output | 1 | Upstream READY |
| s_data_i | input | DATA_W | Upstream payload |
| m_valid_o | output | 1 | Downstream VALID |
| m_ready_i | input | 1 | Downstream READY |
| m_data_o | output | DATA_W | Downstream payload |
| mon_rvalid_i | input | 1 | Monitored RVALID |
| mon_rresp_i | input | 2 | Monitored RRESP |
| mon_bvalid_i | input | 1 | Monitored BVALID |
| mon_bresp_i | input | 2 | Monitored BRESP |
| mon_wvalid_i | input | 1 | Monitored WVALID |
| mon_wlast_i | input | 1 | Monitored WLAST |
| mon_arvalid_i | input | 1 | Monitored ARVALID |
| mon_arready_i | input | 1 | Monitored ARREADY |
| mon_awvalid_i | input | 1 | Monitored AWVALID |
| mon_awready_i | input | 1 | Monitored AWREADY |

## Verification
The bench uses the default widths (32-bit LFSRs, 9-bit length, 8-bit threshold) and a 16-bit payload. With these widths the exact field positions above can be driven directly. The decision LFSR can be frozen at a chosen seed, which turns the limit and mask comparisons into deterministic outcomes. The stall counter is three bits wider than the length field. A retrigger that adds a second length to one already running therefore stays far from saturation, so the additive and maximum rules give distinct, predictable stall totals.

// File: rtl/stall_inj_pkg.sv
package stall_inj_pkg;

  // register select codes
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_STALL = 3'd1;
  localparam logic [2:0] REG_LFSR0 = 3'd2;  // seed at +0, poly at +1, per LFSR stride 2

  // control bits
  localparam int unsigned CT_BYPASS = 0;
  localparam int unsigned CT_EN0    = 1;

  // flag offsets above the length and threshold fields
  localparam int unsigned FL_RAND   = 0;
  localparam int unsigned FL_MASK   = 1;
  localparam int unsigned FL_UNC    = 2;
  localparam int unsigned FL_UNCA   = 3;
  localparam int unsigned FL_COND   = 4;
  localparam int unsigned FL_CONDA  = 5;
  localparam int unsigned FL_RETRIG = 6;
  localparam int unsigned FL_RMAX   = 7;
  localparam int unsigned FLAG_N    = 8;

  // trigger source order
  localparam int unsigned TR_RERR = 0;
  localparam int unsigned TR_BERR = 1;
  localparam int unsigned TR_WLST = 2;
  localparam int unsigned TR_ARHS = 3;
  localparam int unsigned TR_AWHS = 4;
  localparam int unsigned TRIG_N  = 5;

  localparam int unsigned LFSR_N  = 2;  // 0 decision, 1 length

endpackage

// File: rtl/stall_lfsr.sv
module stall_lfsr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         seed_we_i,
  input  logic         poly_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] seed_q, poly_q, state_q;
  logic [W-1:0] state_d, step;

  always_comb begin
    step    = (state_q >> 1) ^ (state_q[0] ? poly_q : '0);
    state_d = state_q;
    if (seed_we_i) begin
      state_d = wdata_i;
    end else if (en_i) begin
      state_d = (step == '0) ? seed_q : step;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q  <= '1;
      poly_q  <= '1;
      state_q <= '1;
    end else begin
      if (seed_we_i) seed_q <= wdata_i;
      if (poly_we_i) poly_q <= wdata_i;
      if (seed_we_i || en_i) state_q <= state_d;
    end
  end

  assign state_o = state_q;

  // R13
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_we_i |=> state_q == $past(wdata_i));

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !seed_we_i) |=> $stable(state_q));

  // R12
  nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !seed_we_i && !poly_we_i && seed_q != '0 && state_q != '0) |=> state_q != '0);

endmodule

// File: rtl/stall_decide.sv
module stall_decide #(
  parameter int unsigned DLY_W  = 9,
  parameter int unsigned PROB_W = 8
) (
  input  logic [PROB_W-1:0] prob_draw_i,
  input  logic [DLY_W-1:0]  dly_draw_i,
  input  logic [PROB_W-1:0] thresh_i,
  input  logic              mask_mode_i,
  input  logic              rand_en_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic              prob_hit_o,
  output logic [DLY_W-1:0]  new_dly_o
);

  localparam int unsigned PROD_W = 2 * DLY_W;

  logic [PROD_W-1:0] scaled;

  always_comb begin
    if (mask_mode_i) prob_hit_o = (prob_draw_i & thresh_i) == '0;
    else             prob_hit_o = prob_draw_i < thresh_i;

    // draw in [0, 2^DLY_W) scaled onto [0, delay), then shifted to [1, delay]
    scaled = PROD_W'(dly_draw_i) * PROD_W'(delay_i);
    if (delay_i == '0)  new_dly_o = '0;
    else if (rand_en_i) new_dly_o = scaled[PROD_W-1:DLY_W] + DLY_W'(1);
    else                new_dly_o = delay_i;
  end

endmodule

// File: rtl/stall_counter.sv
module stall_counter #(
  parameter int unsigned DLY_W = 9,
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_i,
  input  logic             start_i,
  input  logic             retrig_i,
  input  logic             max_mode_i,
  input  logic [DLY_W-1:0] new_dly_i,
  output logic             busy_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, dec, ext;
  logic [CNT_W:0]   sum;

  always_comb begin
    ext   = CNT_W'(new_dly_i);
    dec   = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
    sum   = {1'b0, dec} + {1'b0, ext};
    cnt_d = dec;
    if (bypass_i) begin
      cnt_d = '0;
    end else if (cnt_q == '0) begin
      cnt_d = start_i ? ext : '0;
    end else if (retrig_i) begin
      if (max_mode_i) cnt_d = (dec > ext) ? dec : ext;
      else            cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy_o = cnt_q != '0;

  // R14
  bypass_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> cnt_q == '0);

  // R4
  countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > CNT_W'(1) && !bypass_i && !retrig_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R10
  retrig_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !bypass_i && retrig_i && max_mode_i) |=> cnt_q >= CNT_W'($past(new_dly_i)));

endmodule

// File: rtl/chan_stall_inj.sv
module chan_stall_inj
  import stall_inj_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned LFSR_W = 32,
  parameter int unsigned DLY_W  = 9,
  parameter int unsigned PROB_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [LFSR_W-1:0] prob_state_o,
  output logic [LFSR_W-1:0] dly_state_o,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  input  logic              mon_rvalid_i,
  input  logic [1:0]        mon_rresp_i,
  input  logic              mon_bvalid_i,
  input  logic [1:0]        mon_bresp_i,
  input  logic              mon_wvalid_i,
  input  logic              mon_wlast_i,
  input  logic              mon_arvalid_i,
  input  logic              mon_arready_i,
  input  logic              mon_awvalid_i,
  input  logic              mon_awready_i
);

  localparam int unsigned CNT_W  = DLY_W + 3;
  localparam int unsigned F_BASE = DLY_W + PROB_W;
  localparam int unsigned T_BASE = F_BASE + FLAG_N;
  localparam int unsigned CFG_W  = T_BASE + TRIG_N;
  localparam int unsigned CTRL_W = 1 + LFSR_N;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  // control and stall configuration registers
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic              ctrl_we, cfg_we;

  always_comb begin
    ctrl_we = reg_we_i && (reg_addr_i == REG_CTRL);
    cfg_we  = reg_we_i && (reg_addr_i == REG_STALL);
    ctrl_d  = ctrl_we ? reg_wdata_i[CTRL_W-1:0] : ctrl_q;
    cfg_d   = cfg_we  ? reg_wdata_i[CFG_W-1:0]  : cfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_W'(1) << CT_BYPASS;
      cfg_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (cfg_we)  cfg_q  <= cfg_d;
    end
  end

  logic              bypass;
  logic [DLY_W-1:0]  cfg_delay;
  logic [PROB_W-1:0] cfg_thresh;
  logic [FLAG_N-1:0] flg;
  logic [TRIG_N-1:0] trig_sel;

  assign bypass     = ctrl_q[CT_BYPASS];
  assign cfg_delay  = cfg_q[DLY_W-1:0];
  assign cfg_thresh = cfg_q[F_BASE-1:DLY_W];
  assign flg        = cfg_q[T_BASE-1:F_BASE];
  assign trig_sel   = cfg_q[CFG_W-1:T_BASE];

  // LFSR bank
  logic [LFSR_W-1:0] lfsr_state [LFSR_N];

  for (genvar g = 0; g < LFSR_N; g++) begin : g_lfsr
    localparam logic [2:0] A_SEED = 3'(REG_LFSR0 + 2 * g);
    localparam logic [2:0] A_POLY = 3'(REG_LFSR0 + 2 * g + 1);
    stall_lfsr #(.W(LFSR_W)) u_lfsr (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .en_i      (ctrl_q[CT_EN0 + g]),
      .seed_we_i (reg_we_i && (reg_addr_i == A_SEED)),
      .poly_we_i (reg_we_i && (reg_addr_i == A_POLY)),
      .wdata_i   (reg_wdata_i[LFSR_W-1:0]),
      .state_o   (lfsr_state[g])
    );
  end

  assign prob_state_o = lfsr_state[0];
  assign dly_state_o  = lfsr_state[1];

  // decision and length
  logic             prob_hit;
  logic [DLY_W-1:0] new_dly;

  stall_decide #(.DLY_W(DLY_W), .PROB_W(PROB_W)) u_decide (
    .prob_draw_i (lfsr_state[0][PROB_W-1:0]),
    .dly_draw_i  (lfsr_state[1][DLY_W-1:0]),
    .thresh_i    (cfg_thresh),
    .mask_mode_i (flg[FL_MASK]),
    .rand_en_i   (flg[FL_RAND]),
    .delay_i     (cfg_delay),
    .prob_hit_o  (prob_hit),
    .new_dly_o   (new_dly)
  );

  // trigger events
  logic [TRIG_N-1:0] trig_ev;
  logic              trig_hit, unc_hit, cond_hit;

  always_comb begin
    trig_ev          = '0;
    trig_ev[TR_RERR] = mon_rvalid_i && (mon_rresp_i != 2'b00);
    trig_ev[TR_BERR] = mon_bvalid_i && (mon_bresp_i != 2'b00);
    trig_ev[TR_WLST] = mon_wvalid_i && mon_wlast_i;
    trig_ev[TR_ARHS] = mon_arvalid_i && mon_arready_i;
    trig_ev[TR_AWHS] = mon_awvalid_i && mon_awready_i;
    trig_hit = |(trig_ev & trig_sel);
    unc_hit  = flg[FL_UNC] && (flg[FL_UNCA] || prob_hit);
    cond_hit = flg[FL_COND] && trig_hit && (flg[FL_CONDA] || prob_hit);
  end

  logic busy, stall;

  stall_counter #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .bypass_i   (bypass),
    .start_i    (unc_hit || cond_hit),
    .retrig_i   (flg[FL_RETRIG] && cond_hit),
    .max_mode_i (flg[FL_RMAX]),
    .new_dly_i  (new_dly),
    .busy_o     (busy)
  );

  assign stall     = busy && !bypass;
  assign m_valid_o = s_valid_i && !stall;
  assign s_ready_o = m_ready_i && !stall;
  assign m_data_o  = s_data_i;

  // R5
  rand_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (flg[FL_RAND] && cfg_delay != '0) |-> (new_dly >= DLY_W'(1) && new_dly <= cfg_delay));

  // R8
  no_trig_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy && !bypass && !flg[FL_UNC] && trig_hit == 1'b0) |=> !busy);

endmodule

// File: tb/chan_stall_inj_tb.sv
`timescale 1ns/1ps
module chan_stall_inj_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] pst, dst;
  logic        s_valid, s_ready, m_valid, m_ready;
  logic [15:0] s_data, m_data;
  logic        rv, bv, wv, wl, arv, arr, awv, awr;
  logic [1:0]  rr, br;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  chan_stall_inj #(.DATA_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .prob_state_o(pst), .dly_state_o(dst),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data),
    .mon_rvalid_i(rv), .mon_rresp_i(rr), .mon_bvalid_i(bv), .mon_bresp_i(br),
    .mon_wvalid_i(wv), .mon_wlast_i(wl), .mon_arvalid_i(arv), .mon_arready_i(arr),
    .mon_awvalid_i(awv), .mon_awready_i(awr)
  );

  // field positions from the requirements
  localparam int F_RAND = 1 << 0, F_MASK = 1 << 1, F_UNC = 1 << 2, F_UNCA = 1 << 3;
  localparam int F_COND = 1 << 4, F_CONDA = 1 << 5, F_RETRIG = 1 << 6, F_RMAX = 1 << 7;
  localparam int F_TR = 1 << 8, F_TB = 1 << 9, F_TW = 1 << 10, F_TAR = 1 << 11, F_TAW = 1 << 12;
  localparam int F_TALL = F_TR | F_TB | F_TW | F_TAR | F_TAW;

  // vector table: stall length, sample window (R4)
  localparam int NV = 6;
  localparam int V_DLY [NV] = '{1, 2, 3, 6, 11, 0};
  localparam int V_WIN [NV] = '{10, 12, 16, 21, 36, 9};

  // trigger table: kind, expected stalled cycles with length 3 (R8)
  localparam int NT = 8;
  localparam int T_KIND [NT] = '{1, 2, 3, 4, 5, 6, 7, 8};
  localparam int T_EXP  [NT] = '{3, 0, 3, 3, 0, 3, 0, 3};

  function automatic logic [31:0] mk(input int dly, input int thr, input int flags);
    return 32'(dly) | (32'(thr) << 9) | (32'(flags) << 17);
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s, input logic [31:0] p,
                                       input logic [31:0] sd);
    logic [31:0] t;
    t = (s >> 1) ^ (s[0] ? p : 32'h0);
    return (t == 32'h0) ? sd : t;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic arm(input logic [31:0] cfg, input logic [2:0] ctrl);
    wr(3'd0, {29'd0, ctrl[2:1], 1'b1});
    wr(3'd1, cfg);
    wr(3'd0, {29'd0, ctrl});
  endtask

  task automatic set_trig(input int kind);
    rv = 0; rr = 0; bv = 0; br = 0; wv = 0; wl = 0; arv = 0; arr = 0; awv = 0; awr = 0;
    case (kind)
      1: begin rv = 1; rr = 2'b10; end
      2: begin rv = 1; rr = 2'b00; end
      3: begin bv = 1; br = 2'b11; end
      4: begin wv = 1; wl = 1; end
      5: begin wv = 1; wl = 0; end
      6: begin arv = 1; arr = 1; end
      7: begin arv = 1; arr = 0; end
      8: begin awv = 1; awr = 1; end
      default: ;
    endcase
  endtask

  task automatic trig_run(input int kind, input int k2, input int win, output int stalls);
    stalls = 0;
    for (int k = 0; k < win; k++) begin
      if (!m_valid) stalls++;
      set_trig((k == 0 || k == k2) ? kind : 0);
      @(negedge clk);
    end
    set_trig(0);
  endtask

  task automatic count_run(input int win, output int stalls);
    stalls = 0;
    for (int k = 0; k < win; k++) begin
      if (!m_valid) stalls++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int st, runs, run;
    logic [31:0] e, a;
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    s_valid = 1; m_ready = 1; s_data = 16'h1234;
    set_trig(0);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(pst == 32'hFFFFFFFF, "R1 decision state", pst, 32'hFFFFFFFF);
    chk(dst == 32'hFFFFFFFF, "R1 length state", dst, 32'hFFFFFFFF);
    chk(m_valid == 1'b1 && s_ready == 1'b1, "R1 transparent", m_valid, 1);
    wr(3'd1, mk(3, 0, F_UNC | F_UNCA));
    count_run(10, st);
    chk(st == 0, "R1 bypass at reset", st, 0);

    // R2 pass-through
    s_data = 16'hA5C3;
    #1 chk(m_data == 16'hA5C3, "R2 data", m_data, 16'hA5C3);
    s_valid = 0;
    #1 chk(m_valid == 1'b0, "R2 valid follows", m_valid, 0);
    s_valid = 1; m_ready = 0;
    #1 chk(s_ready == 1'b0, "R2 ready follows", s_ready, 0);
    m_ready = 1;
    @(negedge clk);

    // R4 / R3 vector table
    for (int v = 0; v < NV; v++) begin
      arm(mk(V_DLY[v], 0, F_UNC | F_UNCA), 3'b000);
      for (int k = 0; k < V_WIN[v]; k++) begin
        bit exp_st;
        exp_st = (V_DLY[v] != 0) && ((k % (V_DLY[v] + 1)) != 0);
        chk(!m_valid == exp_st, "R4 stall pattern", !m_valid, exp_st);
        chk(s_ready == m_valid, "R3 both gated", s_ready, m_valid);
        @(negedge clk);
      end
    end

    // R13 seed reload and readback
    wr(3'd0, 32'd1);
    wr(3'd2, 32'h00000010);
    chk(pst == 32'h00000010, "R13 decision seed", pst, 32'h10);
    wr(3'd4, 32'hCAFE0001);
    chk(dst == 32'hCAFE0001, "R13 length seed", dst, 32'hCAFE0001);

    // R6 limit mode, draw = 0x10
    arm(mk(2, 8'h11, F_UNC), 3'b000);
    count_run(12, st);
    chk(st == 8, "R6 below limit stalls", st, 8);
    arm(mk(2, 8'h10, F_UNC), 3'b000);
    count_run(12, st);
    chk(st == 0, "R6 equal limit no stall", st, 0);

    // R7 mask mode, draw = 0x10
    arm(mk(2, 8'h01, F_UNC | F_MASK), 3'b000);
    count_run(12, st);
    chk(st == 8, "R7 masked zero stalls", st, 8);
    arm(mk(2, 8'h10, F_UNC | F_MASK), 3'b000);
    count_run(12, st);
    chk(st == 0, "R7 masked bit set no stall", st, 0);

    // R8 trigger table
    for (int t = 0; t < NT; t++) begin
      arm(mk(3, 0, F_COND | F_CONDA | F_TALL), 3'b000);
      trig_run(T_KIND[t], -1, 10, st);
      chk(st == T_EXP[t], "R8 trigger source", st, T_EXP[t]);
    end
    arm(mk(3, 0, F_COND | F_CONDA | F_TAR), 3'b000);
    trig_run(8, -1, 10, st);
    chk(st == 0, "R8 unselected source", st, 0);

    // R9 additive retrigger: 2 + (2 + 4)
    arm(mk(4, 0, F_COND | F_CONDA | F_TAR | F_RETRIG), 3'b000);
    trig_run(6, 2, 20, st);
    chk(st == 8, "R9 add", st, 8);
    // R10 max retrigger: 2 + max(2, 4)
    arm(mk(4, 0, F_COND | F_CONDA | F_TAR | F_RETRIG | F_RMAX), 3'b000);
    trig_run(6, 2, 20, st);
    chk(st == 6, "R10 max", st, 6);
    arm(mk(4, 0, F_COND | F_CONDA | F_TAR), 3'b000);
    trig_run(6, 2, 20, st);
    chk(st == 4, "R10 retrigger off ignored", st, 4);

    // R11 stepping and hold
    wr(3'd0, 32'd1);
    wr(3'd2, 32'h12345678);
    wr(3'd3, 32'h80200003);
    wr(3'd0, 32'd3);
    e = 32'h12345678;
    for (int j = 0; j < 6; j++) begin
      chk(pst == e, "R11 step", pst, e);
      e = step(e, 32'h80200003, 32'h12345678);
      @(negedge clk);
    end
    wr(3'd0, 32'd1);
    a = pst;
    repeat (3) @(negedge clk);
    chk(pst == a, "R11 hold when disabled", pst, a);

    // R12 zero forced to seed
    wr(3'd2, 32'd2);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd3);
    e = 32'd2;
    for (int j = 0; j < 5; j++) begin
      chk(pst == e, "R12 zero reload", pst, e);
      e = step(e, 32'd0, 32'd2);
      @(negedge clk);
    end

    // R5 random length
    arm(mk(4, 0, F_RAND | F_UNC | F_UNCA), 3'b100);
    runs = 0; run = 0;
    for (int k = 0; k < 80; k++) begin
      if (!m_valid) run++;
      else begin
        if (run > 0) begin
          chk(run >= 1 && run <= 4, "R5 length range", run, 4);
          runs++;
        end
        run = 0;
      end
      @(negedge clk);
    end
    chk(runs >= 5, "R5 stalls occurred", runs, 5);

    // R14 bypass ends a running stall
    arm(mk(9, 0, F_UNC | F_UNCA), 3'b000);
    @(negedge clk);
    chk(!m_valid, "R14 stall started", m_valid, 0);
    wr(3'd0, 32'd1);
    count_run(8, st);
    chk(st == 0, "R14 bypass clears", st, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule